// File: doc/BRIEF.md
# EEPROM Software Command Sequence Detector

This block sits on the write side of a byte-wide parallel EEPROM interface. Every cycle with `wr_en` high presents one write strobe carrying a 15-bit address and a data byte. The block looks for two six-write unlock sequences. Both use the same first five writes and differ only in the command byte of the sixth. One sequence turns automatic clear-before-write off and the other turns it back on. The block holds the resulting mode bit until reset or the opposite command.

Accepted writes that are not consumed as sequence steps pass through, one cycle later, as ordinary page-write traffic. This includes the data bytes that follow a completed sequence. A page is open from the first such write, or from a completed sequence, until it holds `PAGE_BYTES` bytes or until `PAGE_GAP` cycles pass with no accepted write. The page then closes and a busy timer starts. The busy time is `T_EN_CYC` cycles while autoclear is on and `T_DIS_CYC` cycles while it is off. The busy time with autoclear on defaults to twice the other. While the timer runs, `ready` is low and all write strobes are dropped.

The logic uses three state machines. The matcher has the states SEQ_IDLE and SEQ_GOT1 to SEQ_GOT5. Each expected write advances it one state. From SEQ_GOT5, a write with command 0x40 or 0x50 returns it to SEQ_IDLE and issues the command. Any other write returns it to SEQ_IDLE, except a write that is itself the first step, which sends it to SEQ_GOT1. The page window has the states WIN_CLOSED and WIN_OPEN. It goes from WIN_CLOSED to WIN_OPEN on a forwarded write or a completed sequence, and from WIN_OPEN back to WIN_CLOSED on a full page or an idle gap. The busy timer has the states TMR_READY and TMR_BUSY. It goes to TMR_BUSY when the window closes and back to TMR_READY when the count ends.

Top module: `eeprom_cmd_seq`

## Requirements
- R1: After reset, `autoclr_en` is 1, `ready` is 1 and `page_wr_valid` is 0.
- R2: The six accepted writes 0x5555/0xAA, 0x2AAA/0x55, 0x5555/0x80, 0x5555/0xAA, 0x2AAA/0x55 and 0x5555/0x40 (address/data) clear `autoclr_en`. The new value shows in the cycle after the sixth write.
- R3: The same five leading writes followed by 0x5555/0x50 set `autoclr_en` to 1, with the same timing.
- R4: `autoclr_en` changes only in the cycle after an accepted sixth step of a sequence.
- R5: A write that does not match the expected step returns the matcher to idle. If that write is 0x5555/0xAA, the matcher counts it as step one and expects step two next.
- R6: A sixth write with any byte other than 0x40 or 0x50 aborts the sequence and leaves `autoclr_en` unchanged. That write is then forwarded as page traffic.
- R7: Sequence-step writes are consumed and not forwarded. Every other accepted write shows on `page_wr_valid`/`page_wr_addr`/`page_wr_data` exactly one cycle after it is accepted, with the same address and data.
- R8: The page closes, and `ready` falls in the cycle after, in one of two ways. Either the write that makes `PAGE_BYTES` forwarded bytes is accepted, or `PAGE_GAP` consecutive cycles pass with no accepted write after the page opened. A completed sequence opens a page on its own.
- R9: `ready` stays low for exactly `T_EN_CYC` cycles when `autoclr_en` is 1 and exactly `T_DIS_CYC` cycles when it is 0.
- R10: A write strobe in a cycle where `ready` is low has no effect. Nothing is forwarded, the sequence does not advance and the mode does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| wr_en | input | 1 | Write strobe, one write per cycle while high |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data byte |
| ready | output | 1 | High when writes are accepted; low while busy |
| autoclr_en | output | 1 | 1 when automatic clear-before-write is on |
| page_wr_valid | output | 1 | Forwarded page-write byte is valid |
| page_wr_addr | output | ADDR_W | Address of the forwarded byte |
| page_wr_data | output | DATA_W | Data of the forwarded byte |

## Verification
Two events can fall in the same cycle: a write strobe arriving in the last idle cycle of the page gap, and a strobe arriving in the cycle where the busy timer releases `ready`. The first must keep the page open. The second must be accepted only once `ready` reads high. Random bursts are driven without waiting for `ready`, and are interleaved with idle gaps of random length around `PAGE_GAP`, so both collisions occur many times. A cycle-accurate bench model built from the requirements predicts `ready`, the mode bit and every forwarded byte, and each cycle is compared against it.

// File: rtl/eeprom_cmd_pkg.sv
package eeprom_cmd_pkg;

    // Unlock sequence key values (address / data)
    localparam int unsigned SEQ_ADDR_HI = 32'h5555;
    localparam int unsigned SEQ_ADDR_LO = 32'h2AAA;
    localparam int unsigned KEY_A       = 32'hAA;
    localparam int unsigned KEY_B       = 32'h55;
    localparam int unsigned KEY_C       = 32'h80;
    localparam int unsigned CMD_OFF     = 32'h40;
    localparam int unsigned CMD_ON      = 32'h50;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_GOT1,
        SEQ_GOT2,
        SEQ_GOT3,
        SEQ_GOT4,
        SEQ_GOT5
    } seq_state_t;

    typedef enum logic {
        WIN_CLOSED,
        WIN_OPEN
    } win_state_t;

    typedef enum logic {
        TMR_READY,
        TMR_BUSY
    } tmr_state_t;

endpackage

// File: rtl/eeprom_seq_match.sv
module eeprom_seq_match
    import eeprom_cmd_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              consume,
    output logic              cmd_off,
    output logic              cmd_on
);

    seq_state_t state_q;
    seq_state_t state_d;

    logic at_hi;
    logic at_lo;
    logic is_first;
    logic step_hit;
    logic byte_off;
    logic byte_on;

    // Decode of the address/data pair presented this cycle
    always_comb begin
        at_hi    = (addr == ADDR_W'(SEQ_ADDR_HI));
        at_lo    = (addr == ADDR_W'(SEQ_ADDR_LO));
        byte_off = (data == DATA_W'(CMD_OFF));
        byte_on  = (data == DATA_W'(CMD_ON));
        is_first = at_hi && (data == DATA_W'(KEY_A));
    end

    // Does the write match the step the current state expects
    always_comb begin
        step_hit = 1'b0;
        unique case (state_q)
            SEQ_IDLE: step_hit = is_first;
            SEQ_GOT1: step_hit = at_lo && (data == DATA_W'(KEY_B));
            SEQ_GOT2: step_hit = at_hi && (data == DATA_W'(KEY_C));
            SEQ_GOT3: step_hit = is_first;
            SEQ_GOT4: step_hit = at_lo && (data == DATA_W'(KEY_B));
            SEQ_GOT5: step_hit = at_hi && (byte_off || byte_on);
            default:  step_hit = 1'b0;
        endcase
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (accept) begin
            if (step_hit) begin
                unique case (state_q)
                    SEQ_IDLE: state_d = SEQ_GOT1;
                    SEQ_GOT1: state_d = SEQ_GOT2;
                    SEQ_GOT2: state_d = SEQ_GOT3;
                    SEQ_GOT3: state_d = SEQ_GOT4;
                    SEQ_GOT4: state_d = SEQ_GOT5;
                    SEQ_GOT5: state_d = SEQ_IDLE;
                    default:  state_d = SEQ_IDLE;
                endcase
            end else if (is_first) begin
                state_d = SEQ_GOT1;
            end else begin
                state_d = SEQ_IDLE;
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs
    always_comb begin
        consume = accept && (step_hit || is_first);
        cmd_off = accept && (state_q == SEQ_GOT5) && at_hi && byte_off;
        cmd_on  = accept && (state_q == SEQ_GOT5) && at_hi && byte_on;
    end

endmodule

// File: rtl/eeprom_page_window.sv
module eeprom_page_window
    import eeprom_cmd_pkg::*;
#(
    parameter int PAGE_BYTES = 64,
    parameter int PAGE_GAP   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic fwd,
    input  logic seq_done,
    output logic close
);

    localparam int CNT_W = $clog2(PAGE_BYTES + 1);
    localparam int GAP_W = $clog2(PAGE_GAP + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PAGE_BYTES - 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(PAGE_GAP - 1);

    win_state_t       state_q;
    win_state_t       state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic [GAP_W-1:0] gap_q;
    logic [GAP_W-1:0] gap_d;
    logic             full_hit;
    logic             gap_hit;

    always_comb begin
        full_hit = fwd && (cnt_q == CNT_LAST);
        gap_hit  = !accept && (gap_q == GAP_LAST);
    end

    // Next state and counters
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        gap_d   = gap_q;
        unique case (state_q)
            WIN_CLOSED: begin
                if (fwd || seq_done) begin
                    state_d = WIN_OPEN;
                    cnt_d   = fwd ? CNT_W'(1) : '0;
                    gap_d   = '0;
                end
            end
            WIN_OPEN: begin
                if (full_hit || gap_hit) begin
                    state_d = WIN_CLOSED;
                    cnt_d   = '0;
                    gap_d   = '0;
                end else if (accept) begin
                    gap_d = '0;
                    if (fwd) begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end else begin
                    gap_d = gap_q + GAP_W'(1);
                end
            end
            default: state_d = WIN_CLOSED;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WIN_CLOSED;
            cnt_q   <= '0;
            gap_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            gap_q   <= gap_d;
        end
    end

    // Outputs
    always_comb begin
        close = (state_q == WIN_OPEN) && (full_hit || gap_hit);
    end

endmodule

// File: rtl/eeprom_busy_timer.sv
module eeprom_busy_timer
    import eeprom_cmd_pkg::*;
#(
    parameter int T_DIS_CYC = 40,
    parameter int T_EN_CYC  = 2 * T_DIS_CYC
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic autoclr,
    output logic ready
);

    localparam int T_MAX = (T_EN_CYC > T_DIS_CYC) ? T_EN_CYC : T_DIS_CYC;
    localparam int TW    = $clog2(T_MAX + 1);
    localparam logic [TW-1:0] LOAD_EN  = TW'(T_EN_CYC - 1);
    localparam logic [TW-1:0] LOAD_DIS = TW'(T_DIS_CYC - 1);

    tmr_state_t    state_q;
    tmr_state_t    state_d;
    logic [TW-1:0] cnt_q;
    logic [TW-1:0] cnt_d;

    // Next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TMR_READY: begin
                if (start) begin
                    state_d = TMR_BUSY;
                    cnt_d   = autoclr ? LOAD_EN : LOAD_DIS;
                end
            end
            TMR_BUSY: begin
                if (cnt_q == '0) begin
                    state_d = TMR_READY;
                end else begin
                    cnt_d = cnt_q - TW'(1);
                end
            end
            default: state_d = TMR_READY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TMR_READY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        ready = (state_q == TMR_READY);
    end

endmodule

// File: rtl/eeprom_cmd_seq.sv
module eeprom_cmd_seq
    import eeprom_cmd_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int DATA_W     = 8,
    parameter int PAGE_BYTES = 64,
    parameter int PAGE_GAP   = 8,
    parameter int T_DIS_CYC  = 40,
    parameter int T_EN_CYC   = 2 * T_DIS_CYC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ready,
    output logic              autoclr_en,
    output logic              page_wr_valid,
    output logic [ADDR_W-1:0] page_wr_addr,
    output logic [DATA_W-1:0] page_wr_data
);

    logic accept;
    logic consume;
    logic fwd;
    logic cmd_off;
    logic cmd_on;
    logic win_close;
    logic tmr_ready;

    logic              mode_q;
    logic              pv_q;
    logic [ADDR_W-1:0] pa_q;
    logic [DATA_W-1:0] pd_q;

    always_comb begin
        accept = wr_en && tmr_ready;
        fwd    = accept && !consume;
    end

    eeprom_seq_match #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .addr    (wr_addr),
        .data    (wr_data),
        .consume (consume),
        .cmd_off (cmd_off),
        .cmd_on  (cmd_on)
    );

    eeprom_page_window #(
        .PAGE_BYTES (PAGE_BYTES),
        .PAGE_GAP   (PAGE_GAP)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .fwd      (fwd),
        .seq_done (cmd_off || cmd_on),
        .close    (win_close)
    );

    eeprom_busy_timer #(
        .T_DIS_CYC (T_DIS_CYC),
        .T_EN_CYC  (T_EN_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (win_close),
        .autoclr (mode_q),
        .ready   (tmr_ready)
    );

    // Mode register: autoclear on at power-up
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= 1'b1;
        end else if (cmd_off) begin
            mode_q <= 1'b0;
        end else if (cmd_on) begin
            mode_q <= 1'b1;
        end
    end

    // Forwarded page traffic register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pv_q <= 1'b0;
            pa_q <= '0;
            pd_q <= '0;
        end else begin
            pv_q <= fwd;
            if (fwd) begin
                pa_q <= wr_addr;
                pd_q <= wr_data;
            end
        end
    end

    always_comb begin
        ready         = tmr_ready;
        autoclr_en    = mode_q;
        page_wr_valid = pv_q;
        page_wr_addr  = pa_q;
        page_wr_data  = pd_q;
    end

endmodule

// File: rtl/eeprom_cmd_seq_chk.sv
module eeprom_cmd_seq_chk
    import eeprom_cmd_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    parameter int T_DIS_CYC = 40,
    parameter int T_EN_CYC  = 80
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              ready,
    input logic              autoclr_en,
    input logic              page_wr_valid,
    input logic [ADDR_W-1:0] page_wr_addr,
    input logic [DATA_W-1:0] page_wr_data
);

    logic [31:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (!ready) begin
            low_run <= low_run + 32'd1;
        end else begin
            low_run <= '0;
        end
    end

    assert_fwd_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        page_wr_valid |-> ($past(wr_en) && $past(ready)
                           && page_wr_addr == $past(wr_addr)
                           && page_wr_data == $past(wr_data)));

    assert_mode_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (autoclr_en != $past(autoclr_en)) |->
            ($past(wr_en) && $past(ready) && $past(wr_addr) == ADDR_W'(SEQ_ADDR_HI)));

    assert_off_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(autoclr_en) |-> ($past(wr_data) == DATA_W'(CMD_OFF)));

    assert_on_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(autoclr_en) |-> ($past(wr_data) == DATA_W'(CMD_ON)));

    assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> (!page_wr_valid && $stable(autoclr_en)));

    assert_busy_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> (low_run == (autoclr_en ? 32'(T_EN_CYC) : 32'(T_DIS_CYC))));

endmodule

bind eeprom_cmd_seq eeprom_cmd_seq_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .T_DIS_CYC (T_DIS_CYC),
    .T_EN_CYC  (T_EN_CYC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .ready         (ready),
    .autoclr_en    (autoclr_en),
    .page_wr_valid (page_wr_valid),
    .page_wr_addr  (page_wr_addr),
    .page_wr_data  (page_wr_data)
);

// File: tb/eeprom_cmd_seq_tb.sv
`timescale 1ns/1ps
module eeprom_cmd_seq_tb;

    localparam int PB   = 64;
    localparam int GAP  = 8;
    localparam int TDIS = 40;
    localparam int TEN  = 2 * TDIS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        ready;
    logic        autoclr_en;
    logic        page_wr_valid;
    logic [14:0] page_wr_addr;
    logic [7:0]  page_wr_data;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc_n   = 0;

    // bench model state
    int          m_step = 0;
    bit          m_mode = 1'b1;
    bit          m_open = 1'b0;
    int          m_cnt = 0;
    int          m_gap = 0;
    int          m_busy = 0;
    bit          m_v = 1'b0;
    logic [14:0] m_a = '0;
    logic [7:0]  m_d = '0;

    always #2 clk = ~clk;

    eeprom_cmd_seq #(
        .ADDR_W(15), .DATA_W(8), .PAGE_BYTES(PB), .PAGE_GAP(GAP),
        .T_DIS_CYC(TDIS), .T_EN_CYC(TEN)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ready(ready), .autoclr_en(autoclr_en), .page_wr_valid(page_wr_valid),
        .page_wr_addr(page_wr_addr), .page_wr_data(page_wr_data)
    );

    task automatic chk(bit ok, string req, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc_n);
        end
    endtask

    function automatic bit step_match(int step, logic [14:0] a, logic [7:0] d);
        case (step)
            0: return a == 15'h5555 && d == 8'hAA;
            1: return a == 15'h2AAA && d == 8'h55;
            2: return a == 15'h5555 && d == 8'h80;
            3: return a == 15'h5555 && d == 8'hAA;
            4: return a == 15'h2AAA && d == 8'h55;
            5: return a == 15'h5555 && (d == 8'h40 || d == 8'h50);
            default: return 1'b0;
        endcase
    endfunction

    task automatic model_step(bit w, logic [14:0] a, logic [7:0] d);
        bit acc;
        bit cons;
        bit done;
        bit close;
        bit fwd;
        bit first;
        acc = w && (m_busy == 0);
        cons = 0; done = 0; close = 0;
        first = (a == 15'h5555 && d == 8'hAA);
        if (acc) begin
            if (step_match(m_step, a, d)) begin
                cons = 1;
                if (m_step == 5) begin
                    done = 1;
                    m_step = 0;
                end else begin
                    m_step++;
                end
            end else if (first) begin
                cons = 1;
                m_step = 1;
            end else begin
                m_step = 0;
            end
        end
        fwd = acc && !cons;
        if (m_open) begin
            if (fwd && m_cnt == PB - 1) close = 1;
            else if (!acc && m_gap == GAP - 1) close = 1;
        end
        if (m_busy > 0) m_busy--;
        if (close) m_busy = m_mode ? TEN : TDIS;
        if (!m_open) begin
            if (fwd || done) begin
                m_open = 1; m_cnt = fwd ? 1 : 0; m_gap = 0;
            end
        end else if (close) begin
            m_open = 0; m_cnt = 0; m_gap = 0;
        end else if (acc) begin
            m_gap = 0;
            if (fwd) m_cnt++;
        end else begin
            m_gap++;
        end
        if (done) m_mode = (d == 8'h50);
        m_v = fwd;
        if (fwd) begin
            m_a = a; m_d = d;
        end
    endtask

    // one clock: drive, update model at edge, compare just after
    task automatic cyc(bit w, logic [14:0] a, logic [7:0] d);
        wr_en = w; wr_addr = a; wr_data = d;
        @(posedge clk);
        model_step(w, a, d);
        #1;
        chk(ready == (m_busy == 0), "R9/R10 ready", int'(ready), int'(m_busy == 0));
        chk(autoclr_en == m_mode, "R4 mode", int'(autoclr_en), int'(m_mode));
        chk(page_wr_valid == m_v, "R7 fwd valid", int'(page_wr_valid), int'(m_v));
        if (m_v) begin
            chk(page_wr_addr == m_a, "R7 fwd addr", int'(page_wr_addr), int'(m_a));
            chk(page_wr_data == m_d, "R7 fwd data", int'(page_wr_data), int'(m_d));
        end
    endtask

    task automatic seq(logic [7:0] cmd);
        cyc(1, 15'h5555, 8'hAA);
        cyc(1, 15'h2AAA, 8'h55);
        cyc(1, 15'h5555, 8'h80);
        cyc(1, 15'h5555, 8'hAA);
        cyc(1, 15'h2AAA, 8'h55);
        cyc(1, 15'h5555, cmd);
    endtask

    task automatic settle();
        int run = 0;
        for (int i = 0; i < 400 && run < GAP + 2; i++) begin
            cyc(0, '0, '0);
            run = ready ? run + 1 : 0;
        end
    endtask

    // idle until busy; return idle count to fall and low length
    task automatic measure(output int to_fall, output int low_len);
        to_fall = 0; low_len = 0;
        do begin
            cyc(0, '0, '0);
            to_fall++;
        end while (ready && to_fall < 200);
        low_len = 1;
        while (!ready && low_len < 500) begin
            cyc(0, '0, '0);
            if (!ready) low_len++;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc_n++;
            if (cyc_n > 150000) begin
                n_fail++;
                n_tests++;
                $display("FAIL watchdog actual=%0d expected<150000", cyc_n);
                $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    initial begin
        int f;
        int l;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        chk(ready == 1'b1, "R1 ready", int'(ready), 1);
        chk(autoclr_en == 1'b1, "R1 autoclr", int'(autoclr_en), 1);
        chk(page_wr_valid == 1'b0, "R1 valid", int'(page_wr_valid), 0);

        // R2: disable, page opened by sequence closes after gap, short busy
        seq(8'h40);
        chk(autoclr_en == 1'b0, "R2 disabled", int'(autoclr_en), 0);
        measure(f, l);
        chk(f == GAP, "R8 gap close", f, GAP);
        chk(l == TDIS, "R9 disabled busy", l, TDIS);
        settle();

        // R3: enable again, long busy; strobes during busy ignored (R10)
        seq(8'h50);
        chk(autoclr_en == 1'b1, "R3 enabled", int'(autoclr_en), 1);
        while (ready) cyc(0, '0, '0);
        seq(8'h40);
        chk(autoclr_en == 1'b1, "R10 busy seq ignored", int'(autoclr_en), 1);
        chk(page_wr_valid == 1'b0, "R10 busy no fwd", int'(page_wr_valid), 0);
        settle();

        // R5: broken step 3 then remainder, mode unchanged
        cyc(1, 15'h5555, 8'hAA);
        cyc(1, 15'h2AAA, 8'h55);
        cyc(1, 15'h5555, 8'h81);
        chk(page_wr_valid == 1'b1 && page_wr_data == 8'h81, "R5 mismatch fwd", int'(page_wr_data), 8'h81);
        cyc(1, 15'h5555, 8'hAA);
        cyc(1, 15'h2AAA, 8'h55);
        cyc(1, 15'h5555, 8'h40);
        chk(autoclr_en == 1'b1, "R5 abort keeps mode", int'(autoclr_en), 1);
        settle();

        // R5: repeated first step restarts at step two
        cyc(1, 15'h5555, 8'hAA);
        seq(8'h40);
        chk(autoclr_en == 1'b0, "R5 restart", int'(autoclr_en), 0);
        settle();

        // R6: bad command byte aborts, forwarded
        seq(8'h60);
        chk(autoclr_en == 1'b0, "R6 mode kept", int'(autoclr_en), 0);
        chk(page_wr_valid == 1'b1 && page_wr_data == 8'h60, "R6 bad byte fwd", int'(page_wr_data), 8'h60);
        settle();

        // R7: enable then page data
        seq(8'h50);
        for (int i = 0; i < 3; i++) begin
            cyc(1, 15'(16'h0300 + i), 8'(8'h11 * (i + 1)));
            chk(page_wr_valid && page_wr_addr == 15'(16'h0300 + i), "R7 post-seq data", int'(page_wr_addr), 16'h0300 + i);
        end
        settle();

        // R8: full page closes on count; R9 enabled busy length
        for (int i = 0; i < PB; i++) cyc(1, 15'(16'h0100 + i), 8'(i));
        chk(ready == 1'b0, "R8 count close", int'(ready), 0);
        l = 1;
        while (!ready && l < 500) begin
            cyc(1, 15'h0055, 8'h33);
            if (!ready) l++;
        end
        chk(l == TEN, "R9 enabled busy", l, TEN);
        settle();

        // random bursts, model-checked every cycle
        for (int b = 0; b < 90; b++) begin
            int kind = $urandom % 3;
            if (kind == 0) begin
                logic [7:0] cmd;
                int bad;
                int k = $urandom % 3;
                cmd = (k == 0) ? 8'h40 : (k == 1) ? 8'h50 : 8'($urandom);
                bad = ($urandom % 4 == 0) ? int'($urandom % 6) : -1;
                while (!ready) cyc(0, '0, '0);
                for (int s = 0; s < 6; s++) begin
                    logic [14:0] a;
                    logic [7:0]  d;
                    a = (s == 1 || s == 4) ? 15'h2AAA : 15'h5555;
                    d = (s == 0 || s == 3) ? 8'hAA : (s == 1 || s == 4) ? 8'h55 : (s == 2) ? 8'h80 : cmd;
                    if (s == bad) d = 8'($urandom);
                    cyc(1, a, d);
                end
                for (int j = 0; j < int'($urandom % 10); j++)
                    cyc($urandom % 4 != 0, 15'($urandom), 8'($urandom));
            end else begin
                for (int j = 0; j < 20; j++)
                    cyc($urandom % 2 == 0, ($urandom % 3 == 0) ? 15'h5555 : 15'($urandom), 8'($urandom));
            end
            for (int j = 0; j < int'($urandom % (GAP + 4)); j++) cyc(0, '0, '0);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule